// File: doc/BRIEF.md
# Six-Pulse Thyristor Gate Sequencer

This block drives the six gate lines of a three-phase, fully controlled thyristor bridge. Its only timing reference is one digital line from an external phase-crossing comparator. An interlock at power-up keeps the outputs dark while that line is already high. The sequencer arms once it has seen the line low. It starts on the next rising edge of the line.

After the start edge it waits a fixed firing-angle delay. It then plays a 20 ms frame without end. The frame holds six 1 ms gate pulses, each on one output bit in a fixed, non-sequential channel order, with an all-low gap after each pulse. The gaps are 2333 µs and 2334 µs in a fixed mix, so that a frame lasts exactly 20000 µs. Later comparator edges are ignored.

All durations are counted in microsecond ticks from a prescaler set by the number of clock cycles per microsecond. A two-bit status output shows the phase of the sequencer.

Top module: `thy_gate_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, gate_o is 0 and status_o is 0 (waiting), whatever the state was before.
- R2: While the synchronized comparator is high and the block is waiting, status_o stays 0 and gate_o stays 0. This includes a line that is high when reset is released.
- R3: A low comparator input moves status_o from 0 to 1 (armed) exactly three clocks after the input changes. Status 0 can only lead to status 1.
- R4: In the armed state a rising comparator input moves status_o to 2 (delaying) exactly three clocks after the input rises. Without a rising edge the block stays armed.
- R5: status_o stays 2 with gate_o all low for DELAY_US microseconds (default 4000), that is DELAY_US*CYC_PER_US clocks. The first gate pulse then begins.
- R6: Each gate pulse drives exactly one bit of gate_o high for PULSE_US microseconds (default 1000).
- R7: Pulses fire on gate_o bits in the repeating order 0, 5, 1, 3, 2, 4.
- R8: After the pulses on bits 0, 5, 1, 3, 2, 4 the all-low gaps last 2333, 2334, 2333, 2333, 2334 and 2333 µs, so a frame is 20000 µs.
- R9: Once pulses have begun, status_o is 3 (running) and the pattern repeats without end. Comparator activity has no effect on it.
- R10: At most one gate_o bit is high in any clock. Every pulse starts from an all-low gate_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| comp_i | input | 1 | Asynchronous phase-crossing comparator line |
| gate_o | output | 6 | Gate drive vector, one bit per thyristor |
| status_o | output | 2 | 0 waiting, 1 armed, 2 delaying, 3 running |

## Verification
The bench releases reset once with the comparator line high and once with it low. A synchronizer that came out of reset low would arm at once and take the first high sample as a start edge. A design that loses the interlock would show status 2 during the high phase.

Each delay, pulse and gap is checked cycle by cycle at its exact length. A gap that is off by one, a swapped 2333/2334 entry or a wrong channel order shows up as a mismatch on the following segment. Random comparator toggling runs during two full frames and would expose any resynchronisation. A reset in the middle of a pulse must return the block to waiting at once.

// File: rtl/gs_pkg.sv
package gs_pkg;

    localparam int NCH = 6;
    localparam int NSLOT = 6;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DELAY = 2'd2,
        ST_RUN   = 2'd3
    } gs_state_e;

    // Firing order of the bridge: slot index -> one-hot gate vector
    function automatic logic [NCH-1:0] gate_for(input logic [2:0] slot);
        logic [NCH-1:0] g;
        g = '0;
        case (slot)
            3'd0: g[0] = 1'b1;
            3'd1: g[5] = 1'b1;
            3'd2: g[1] = 1'b1;
            3'd3: g[3] = 1'b1;
            3'd4: g[2] = 1'b1;
            3'd5: g[4] = 1'b1;
            default: g = '0;
        endcase
        return g;
    endfunction

    // Slots whose trailing gap takes the extra microsecond
    function automatic logic gap_is_long(input logic [2:0] slot);
        return (slot == 3'd1) || (slot == 3'd4);
    endfunction

endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level_o,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.pipe = {cur_q.pipe[STAGES-2:0], din};
        nxt_d.prev = cur_q.pipe[STAGES-1];
    end

    // Reset to the high level: a line that is already high must not look like an edge
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.pipe <= '1;
            cur_q.prev <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign level_o = cur_q.pipe[STAGES-1];
    assign rise_o  = cur_q.pipe[STAGES-1] & ~cur_q.prev;

endmodule

// File: rtl/gs_tick.sv
module gs_tick #(
    parameter int CYC_PER_US = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);

    localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (clr_i || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/gs_seq.sv
module gs_seq
    import gs_pkg::*;
#(
    parameter int DELAY_US     = 4000,
    parameter int PULSE_US     = 1000,
    parameter int GAP_SHORT_US = 2333,
    parameter int GAP_LONG_US  = 2334
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           level_i,
    input  logic           rise_i,
    input  logic           tick_i,
    output logic           clr_o,
    output logic [NCH-1:0] gate_o,
    output gs_state_e      state_o
);

    localparam int MAXD_A = (DELAY_US > PULSE_US) ? DELAY_US : PULSE_US;
    localparam int MAXD_B = (GAP_SHORT_US > GAP_LONG_US) ? GAP_SHORT_US : GAP_LONG_US;
    localparam int MAXD   = (MAXD_A > MAXD_B) ? MAXD_A : MAXD_B;
    localparam int CW     = $clog2(MAXD + 1);

    localparam logic [CW-1:0] DELAY_LAST = CW'(DELAY_US - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_US - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(GAP_SHORT_US - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(GAP_LONG_US - 1);

    typedef struct packed {
        gs_state_e      st;
        logic [2:0]     slot;
        logic           pulse;
        logic [CW-1:0]  ucnt;
        logic [NCH-1:0] gate;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic [CW-1:0] seg_last;
    logic [2:0]    slot_next;

    always_comb begin
        nxt_d     = cur_q;
        seg_last  = cur_q.pulse ? PULSE_LAST
                  : (gap_is_long(cur_q.slot) ? LONG_LAST : SHORT_LAST);
        slot_next = (cur_q.slot == 3'(NSLOT - 1)) ? 3'd0 : cur_q.slot + 3'd1;

        unique case (cur_q.st)
            ST_WAIT: begin
                if (!level_i) begin
                    nxt_d.st = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (rise_i) begin
                    nxt_d.st   = ST_DELAY;
                    nxt_d.ucnt = '0;
                end
            end
            ST_DELAY: begin
                if (tick_i) begin
                    if (cur_q.ucnt == DELAY_LAST) begin
                        nxt_d.st    = ST_RUN;
                        nxt_d.slot  = 3'd0;
                        nxt_d.pulse = 1'b1;
                        nxt_d.ucnt  = '0;
                        nxt_d.gate  = gate_for(3'd0);
                    end else begin
                        nxt_d.ucnt = cur_q.ucnt + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (tick_i) begin
                    if (cur_q.ucnt == seg_last) begin
                        nxt_d.ucnt = '0;
                        if (cur_q.pulse) begin
                            nxt_d.pulse = 1'b0;
                            nxt_d.gate  = '0;
                        end else begin
                            nxt_d.pulse = 1'b1;
                            nxt_d.slot  = slot_next;
                            nxt_d.gate  = gate_for(slot_next);
                        end
                    end else begin
                        nxt_d.ucnt = cur_q.ucnt + 1'b1;
                    end
                end
            end
            default: nxt_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st    <= ST_WAIT;
            cur_q.slot  <= '0;
            cur_q.pulse <= 1'b0;
            cur_q.ucnt  <= '0;
            cur_q.gate  <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign clr_o   = (cur_q.st == ST_WAIT) || (cur_q.st == ST_ARMED);
    assign gate_o  = cur_q.gate;
    assign state_o = cur_q.st;

    AST_GATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cur_q.gate)); // R10

    AST_PULSE_FROM_DARK: assert property (@(posedge clk) disable iff (rst)
        (cur_q.gate != '0 && cur_q.gate != $past(cur_q.gate)) |-> $past(cur_q.gate) == '0); // R10

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_WAIT && level_i) |=> cur_q.st == ST_WAIT); // R2

    AST_WAIT_EXIT_ARM: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_WAIT) |=> (cur_q.st == ST_WAIT || cur_q.st == ST_ARMED)); // R3

    AST_ARMED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_ARMED && !rise_i) |=> cur_q.st == ST_ARMED); // R4

    AST_DARK_UNTIL_RUN: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st != ST_RUN) |-> cur_q.gate == '0); // R5

    AST_NO_RESYNC: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_RUN) |=> cur_q.st == ST_RUN); // R9

endmodule

// File: rtl/thy_gate_seq.sv
module thy_gate_seq #(
    parameter int CYC_PER_US   = 200,
    parameter int SYNC_STAGES  = 2,
    parameter int DELAY_US     = 4000,
    parameter int PULSE_US     = 1000,
    parameter int GAP_SHORT_US = 2333,
    parameter int GAP_LONG_US  = 2334
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       comp_i,
    output logic [5:0] gate_o,
    output logic [1:0] status_o
);

    import gs_pkg::*;

    logic      level_w;
    logic      rise_w;
    logic      tick_w;
    logic      clr_w;
    gs_state_e state_w;

    gs_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .din     (comp_i),
        .level_o (level_w),
        .rise_o  (rise_w)
    );

    gs_tick #(
        .CYC_PER_US (CYC_PER_US)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr_w),
        .tick_o (tick_w)
    );

    gs_seq #(
        .DELAY_US     (DELAY_US),
        .PULSE_US     (PULSE_US),
        .GAP_SHORT_US (GAP_SHORT_US),
        .GAP_LONG_US  (GAP_LONG_US)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .level_i (level_w),
        .rise_i  (rise_w),
        .tick_i  (tick_w),
        .clr_o   (clr_w),
        .gate_o  (gate_o),
        .state_o (state_w)
    );

    assign status_o = state_w;

endmodule

// File: tb/test_thy_gate_seq.sv
`timescale 1ns/1ps
module test_thy_gate_seq;

    localparam int C = 2;
    localparam int DELAY_US = 4000;
    localparam int PULSE_US = 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       comp_i = 1'b1;
    logic [5:0] gate_o;
    logic [1:0] status_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int order [6] = '{0, 5, 1, 3, 2, 4};
    int gaps  [6] = '{2333, 2334, 2333, 2333, 2334, 2333};

    always #2.5 clk = ~clk;

    thy_gate_seq #(
        .CYC_PER_US (C)
    ) i_thy_gate_seq (
        .clk      (clk),
        .rst      (rst),
        .comp_i   (comp_i),
        .gate_o   (gate_o),
        .status_o (status_o)
    );

    function automatic logic [5:0] exp_gate(input int slot);
        return 6'(1 << order[slot % 6]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold a segment for n clocks, checking gate and status each clock
    task automatic check_seg(input logic [5:0] eg, input logic [1:0] es, input int n,
                             input bit noise, input string req);
        int errs = 0;
        int bad_g = 0;
        int bad_s = 0;
        for (int i = 0; i < n; i++) begin
            if (gate_o !== eg || status_o !== es) begin
                if (errs == 0) begin
                    bad_g = int'(gate_o);
                    bad_s = int'(status_o);
                end
                errs++;
            end
            if (noise) comp_i = ($urandom_range(0, 7) == 0) ? ~comp_i : comp_i;
            @(negedge clk);
        end
        check(errs == 0, req, bad_g * 4 + bad_s, int'(eg) * 4 + int'(es));
    endtask

    // Startup: line high for hi clocks, low for lo clocks, then a rising edge
    task automatic start_seq(input int hi, input int lo);
        int errs = 0;
        comp_i = 1'b1;
        for (int i = 0; i < hi; i++) begin
            if (status_o !== 2'd0 || gate_o !== 6'd0) errs++;
            @(negedge clk);
        end
        check(errs == 0, "R2 interlock while high", errs, 0);
        comp_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(status_o == 2'd0, "R3 not armed before sync", int'(status_o), 0);
        @(negedge clk);
        check(status_o == 2'd1, "R3 armed after low", int'(status_o), 1);
        repeat (lo) @(negedge clk);
        check(status_o == 2'd1 && gate_o == 6'd0, "R4 armed hold", int'(status_o), 1);
        comp_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(status_o == 2'd1, "R4 edge latency", int'(status_o), 1);
        @(negedge clk);
        check(status_o == 2'd2, "R4 start on edge", int'(status_o), 2);
    endtask

    task automatic run_slots(input int nslots, input bit noise);
        for (int s = 0; s < nslots; s++) begin
            check_seg(exp_gate(s), 2'd3, PULSE_US * C, noise, "R6 R7 R9 pulse");
            check_seg(6'd0, 2'd3, gaps[s % 6] * C, noise, "R8 R10 gap");
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));

        // Scenario 1: reset released with the line high
        rst = 1'b1;
        comp_i = 1'b1;
        repeat (4) @(negedge clk);
        check(gate_o == 6'd0 && status_o == 2'd0, "R1 reset state", int'(status_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(gate_o == 6'd0 && status_o == 2'd0, "R1 after release", int'(status_o), 0);
        start_seq($urandom_range(5, 40), $urandom_range(4, 30));
        check_seg(6'd0, 2'd2, DELAY_US * C, 1'b1, "R5 firing delay");
        run_slots(12, 1'b1);

        // Scenario 2: reset mid-pulse, then release with the line low
        rst = 1'b1;
        @(negedge clk);
        check(gate_o == 6'd0 && status_o == 2'd0, "R1 reset from run", int'(gate_o), 0);
        comp_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(status_o == 2'd0, "R3 sync latency after reset", int'(status_o), 0);
        @(negedge clk);
        check(status_o == 2'd1, "R3 armed from low reset", int'(status_o), 1);
        repeat (3) @(negedge clk);
        comp_i = 1'b1;
        repeat (3) @(negedge clk);
        check(status_o == 2'd2, "R4 start after low reset", int'(status_o), 2);
        check_seg(6'd0, 2'd2, DELAY_US * C, 1'b0, "R5 firing delay 2");
        check_seg(exp_gate(0), 2'd3, 500 * C, 1'b0, "R6 first half pulse");
        rst = 1'b1;
        @(negedge clk);
        check(gate_o == 6'd0 && status_o == 2'd0, "R1 reset mid pulse", int'(gate_o), 0);
        rst = 1'b0;

        // Scenario 3: random startups, delay and first pulse each
        for (int k = 0; k < 2; k++) begin
            start_seq($urandom_range(4, 60), $urandom_range(4, 50));
            check_seg(6'd0, 2'd2, DELAY_US * C, 1'b0, "R5 firing delay rnd");
            run_slots(1, 1'b1);
            check(gate_o == exp_gate(1), "R7 second channel", int'(gate_o), int'(exp_gate(1)));
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            comp_i = 1'b1;
            @(negedge clk);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule